// File: doc/BRIEF.md
# Looping PCM Sample Voice

This block is one sample-playback voice of a hardware synthesiser. On every tick it moves a fixed-point read position forward by a programmable pitch step. The position has a 16-bit integer part and an 8-bit fraction. The voice reads the signed 8-bit sample at the new integer position from an external synchronous memory. It scales that sample by an unsigned 8-bit channel volume. The result is a sign-extended 16-bit contribution, ready to be added into a mix accumulator.

When the advanced position reaches or passes the loop end, the voice does not jump back to a fixed loop start. It subtracts the loop length from the advanced position instead. The fractional phase survives the wrap, so a looped tone keeps its pitch exactly. A zero step freezes the voice on its current sample.

Top module: `pcm_voice`

## Requirements
- R1: After the asynchronous active-low reset, `valid_o` is low, `sample_o` is zero and the read position is zero. The first tick then addresses the integer part of the step alone.
- R2: On a tick with a non-zero step, the 8.8 unsigned step is added to the 16.8 position. A carry out of the fraction propagates into the integer part. During the tick cycle, `mem_addr_o` shows the new integer position and `mem_rd_o` is high.
- R3: If the advanced integer position is greater than or equal to `loop_end_i`, the stored position is the advanced position minus `loop_len_i` in the integer part. The subtraction is modulo 2^16.
- R4: A wrap never alters the fraction. The fraction after any tick equals the old fraction plus the step fraction, modulo 256.
- R5: A tick with a step of zero leaves the position unchanged and performs no wrap, even when the position is at or beyond the loop end. The same address is read again.
- R6: The memory byte is taken as two's complement and multiplied by the volume taken as unsigned. `sample_o` is bits 15:8 of the 16-bit product, sign-extended to 16 bits.
- R7: `valid_o` is high for exactly one cycle, two clock edges after the edge that samples the tick. `sample_o` changes only when `valid_o` rises and holds its value otherwise.
- R8: The volume is captured at the tick edge. A change on `volume_i` after that edge has no effect on the resulting `sample_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample tick strobe, one cycle |
| step_i | input | 16 | Pitch step, unsigned 8.8 fixed point |
| loop_len_i | input | 16 | Loop length, integer samples |
| loop_end_i | input | 16 | Loop end position, integer samples |
| volume_i | input | 8 | Channel volume, unsigned |
| mem_addr_o | output | 16 | Sample memory read address |
| mem_rd_o | output | 1 | Sample memory read enable |
| mem_data_i | input | 8 | Sample memory read data, valid one cycle after the read |
| sample_o | output | 16 | Scaled signed contribution |
| valid_o | output | 1 | Contribution valid strobe |

## Verification
The position update is driven with whole-number steps, half-sample steps and mixed steps. These separate a correct carry from the fraction from a carry that is dropped or doubled. A short loop with a step that has a non-zero fraction is run through several wraps. This shows subtract-by-length with a kept fraction, and sets it apart from resetting to a loop start or clearing the phase. Zero steps are applied both inside the loop and with the loop end at zero, so holding is distinguished from a spurious wrap. The scaler is tried at its extremes: -128, -1 and +127 samples against volumes 0, 1 and 255. The volume input is also changed between the tick and the output, which exposes a scaler that reads the live input.

// File: rtl/pcm_voice_pkg.sv
package pcm_voice_pkg;
  parameter int unsigned POS_INT_W  = 16;
  parameter int unsigned POS_FRAC_W = 8;
  parameter int unsigned STEP_INT_W = 8;
  parameter int unsigned SAMPLE_W   = 8;
  parameter int unsigned VOL_W      = 8;
  parameter int unsigned OUT_W      = 16;

  localparam int unsigned POS_W  = POS_INT_W + POS_FRAC_W;
  localparam int unsigned STEP_W = STEP_INT_W + POS_FRAC_W;

  typedef struct packed {
    logic [POS_INT_W-1:0]  int_part;
    logic [POS_FRAC_W-1:0] frac_part;
  } pos_t;
endpackage

// File: rtl/pcm_phase_acc.sv
module pcm_phase_acc
  import pcm_voice_pkg::*;
#(
  parameter int unsigned INT_W   = POS_INT_W,
  parameter int unsigned FRAC_W  = POS_FRAC_W,
  parameter int unsigned SINT_W  = STEP_INT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic [SINT_W+FRAC_W-1:0] step_i,
  input  logic [INT_W-1:0]        loop_len_i,
  input  logic [INT_W-1:0]        loop_end_i,
  output logic [INT_W-1:0]        next_int_o
);
  localparam int unsigned PW = INT_W + FRAC_W;
  localparam int unsigned SW = SINT_W + FRAC_W;

  logic [PW-1:0] pos_q, pos_d, adv, wrapped, step_ext;
  logic          step_zero, past_end;

  generate
    if (PW > SW) begin : g_ext
      assign step_ext = {{(PW-SW){1'b0}}, step_i};
    end else begin : g_noext
      assign step_ext = step_i[PW-1:0];
    end
  endgenerate

  assign step_zero = (step_i == '0);
  assign adv       = pos_q + step_ext;
  assign past_end  = (adv[PW-1:FRAC_W] >= loop_end_i);
  // loop length only touches the integer part; fraction passes through
  assign wrapped   = adv - {loop_len_i, {FRAC_W{1'b0}}};

  always_comb begin
    pos_d = pos_q;
    if (!step_zero) pos_d = past_end ? wrapped : adv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (tick_i) pos_q <= pos_d;
  end

  assign next_int_o = pos_d[PW-1:FRAC_W];
endmodule

// File: rtl/pcm_scale.sv
module pcm_scale
  import pcm_voice_pkg::*;
#(
  parameter int unsigned S_W = SAMPLE_W,
  parameter int unsigned V_W = VOL_W,
  parameter int unsigned O_W = OUT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [S_W-1:0] sample_i,
  input  logic [V_W-1:0] vol_i,
  output logic [O_W-1:0] sample_o,
  output logic           valid_o
);
  localparam int unsigned PW = S_W + V_W;

  logic signed [PW-1:0] s_ext, v_ext, prod, scaled;

  assign s_ext  = {{V_W{sample_i[S_W-1]}}, sample_i};
  assign v_ext  = {{S_W{1'b0}}, vol_i};
  assign prod   = s_ext * v_ext;
  assign scaled = prod >>> V_W;

  logic [O_W-1:0] out_d;
  generate
    if (O_W > PW) begin : g_wide
      assign out_d = {{(O_W-PW){scaled[PW-1]}}, scaled};
    end else begin : g_narrow
      assign out_d = scaled[O_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) sample_o <= out_d;
    end
  end
endmodule

// File: rtl/pcm_voice.sv
module pcm_voice
  import pcm_voice_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [STEP_W-1:0]     step_i,
  input  logic [POS_INT_W-1:0]  loop_len_i,
  input  logic [POS_INT_W-1:0]  loop_end_i,
  input  logic [VOL_W-1:0]      volume_i,
  output logic [POS_INT_W-1:0]  mem_addr_o,
  output logic                  mem_rd_o,
  input  logic [SAMPLE_W-1:0]   mem_data_i,
  output logic [OUT_W-1:0]      sample_o,
  output logic                  valid_o
);
  logic [VOL_W-1:0] vol_q;
  logic             rd_pend_q;

  pcm_phase_acc #(
    .INT_W (POS_INT_W),
    .FRAC_W(POS_FRAC_W),
    .SINT_W(STEP_INT_W)
  ) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .step_i    (step_i),
    .loop_len_i(loop_len_i),
    .loop_end_i(loop_end_i),
    .next_int_o(mem_addr_o)
  );

  assign mem_rd_o = tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q     <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      rd_pend_q <= tick_i;
      if (tick_i) vol_q <= volume_i;
    end
  end

  pcm_scale #(
    .S_W(SAMPLE_W),
    .V_W(VOL_W),
    .O_W(OUT_W)
  ) u_scale (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rd_pend_q),
    .sample_i(mem_data_i),
    .vol_i   (vol_q),
    .sample_o(sample_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/pcm_voice_checker.sv
module pcm_voice_checker
  import pcm_voice_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic [STEP_W-1:0]    step_i,
  input logic [POS_INT_W-1:0] mem_addr_o,
  input logic [OUT_W-1:0]     sample_o,
  input logic                 valid_o
);
  logic [POS_INT_W-1:0] last_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_addr_q <= '0;
    else if (tick_i) last_addr_q <= mem_addr_o;
  end

  assert_valid_after_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> ##2 valid_o);

  assert_valid_needs_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i, 2));

  assert_sample_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o));

  assert_sign_extend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sample_o[OUT_W-1:SAMPLE_W] == {(OUT_W-SAMPLE_W){sample_o[SAMPLE_W-1]}}));

  assert_zero_step_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && step_i == '0) |-> (mem_addr_o == last_addr_q));
endmodule

bind pcm_voice pcm_voice_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .step_i    (step_i),
  .mem_addr_o(mem_addr_o),
  .sample_o  (sample_o),
  .valid_o   (valid_o)
);

// File: tb/pcm_voice_bench.sv
`timescale 1ns/1ps
module pcm_voice_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [15:0] step_i = '0, loop_len_i = '0, loop_end_i = '0;
  logic [7:0]  volume_i = '0;
  logic [15:0] mem_addr_o;
  logic        mem_rd_o;
  logic [7:0]  mem_data_i = '0;
  logic [15:0] sample_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [23:0] exp_pos = '0;
  logic [15:0] last_out = '0;

  always #2.5 clk_i = ~clk_i;

  pcm_voice u_pcm_voice (.*);

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    logic [7:0] t;
    if (a[15]) return a[7:0];
    t = a[7:0] * 8'd29;
    return t ^ a[15:8] ^ 8'h5B;
  endfunction

  always @(posedge clk_i) if (mem_rd_o) mem_data_i <= mem_fn(mem_addr_o);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] scale_ref(input logic [7:0] s, input logic [7:0] v);
    int p;
    p = ($signed(s) >= 0 ? int'(s) : int'(s) - 256) * int'(v);
    return 16'(p >>> 8);
  endfunction

  // one tick; vol_late is applied after the tick edge (R8)
  task automatic voice_tick(input logic [15:0] step, input logic [15:0] len,
                            input logic [15:0] lend, input logic [7:0] vol,
                            input logic [7:0] vol_late, input string req);
    logic [23:0] s;
    logic [15:0] exp_out;
    @(negedge clk_i);
    chk({req, " idle valid low R7"}, valid_o, 0);
    chk({req, " idle sample held R7"}, sample_o, last_out);
    if (step != 0) begin
      s = exp_pos + {8'h00, step};
      if (s[23:8] >= lend) s = s - {len, 8'h00};
      exp_pos = s;
    end
    tick_i = 1; step_i = step; loop_len_i = len; loop_end_i = lend; volume_i = vol;
    #1;
    chk({req, " address"}, mem_addr_o, exp_pos[23:8]);
    chk({req, " read strobe R2"}, mem_rd_o, 1);
    @(negedge clk_i);
    tick_i = 0; volume_i = vol_late;
    chk({req, " valid not early R7"}, valid_o, 0);
    @(negedge clk_i);
    exp_out = scale_ref(mem_fn(exp_pos[23:8]), vol);
    chk({req, " valid R7"}, valid_o, 1);
    chk({req, " sample R6"}, sample_o, exp_out);
    last_out = exp_out;
  endtask

  task automatic goto_addr(input logic [15:0] a);
    logic [15:0] len;
    len = exp_pos[23:8] + 16'd1 - a;
    voice_tick(16'h0100, len, 16'h0000, 8'd255, 8'd255, "R3 jump");
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", valid_o, 0);
    chk("R1 sample after reset", sample_o, 0);
    voice_tick(16'h0300, 16'h0000, 16'hFFFF, 8'd200, 8'd200, "R1 first tick");
  endtask

  task automatic t_advance;
    for (int i = 0; i < 3; i++) voice_tick(16'h0100, 0, 16'hFFFF, 8'd128, 8'd128, "R2 whole step");
    voice_tick(16'h0340, 0, 16'hFFFF, 8'd77, 8'd77, "R2 mixed step");
    for (int i = 0; i < 6; i++) voice_tick(16'h0080, 0, 16'hFFFF, 8'd255, 8'd255, "R2 half step carry");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 14; i++) voice_tick(16'h0160, 16'h0008, 16'h0018, 8'd99, 8'd99, "R3 R4 loop wrap");
  endtask

  task automatic t_hold;
    voice_tick(16'h0000, 16'h0008, 16'h0018, 8'd60, 8'd60, "R5 hold in loop");
    voice_tick(16'h0000, 16'h0008, 16'h0000, 8'd60, 8'd60, "R5 hold past end");
    voice_tick(16'h0000, 16'h1234, 16'h0000, 8'd61, 8'd61, "R5 hold again");
  endtask

  task automatic t_scale;
    goto_addr(16'h8080);
    voice_tick(16'h0000, 0, 16'hFFFF, 8'd255, 8'd255, "R6 -128 x 255");
    voice_tick(16'h0000, 0, 16'hFFFF, 8'd1,   8'd1,   "R6 -128 x 1");
    goto_addr(16'h807F);
    voice_tick(16'h0000, 0, 16'hFFFF, 8'd255, 8'd255, "R6 127 x 255");
    voice_tick(16'h0000, 0, 16'hFFFF, 8'd0,   8'd0,   "R6 127 x 0");
    goto_addr(16'h80FF);
    voice_tick(16'h0000, 0, 16'hFFFF, 8'd1,   8'd1,   "R6 -1 x 1");
    voice_tick(16'h0000, 0, 16'hFFFF, 8'd255, 8'd255, "R6 -1 x 255");
  endtask

  task automatic t_vol_capture;
    voice_tick(16'h0000, 0, 16'hFFFF, 8'd255, 8'd0,   "R8 late volume drop");
    voice_tick(16'h0000, 0, 16'hFFFF, 8'd3,   8'd255, "R8 late volume rise");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_advance();
    t_wrap();
    t_hold();
    t_scale();
    t_vol_capture();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule